// File: doc/BRIEF.md
# Serial NAND Transaction Sequencer

This block turns one high-level flash request into the chain of single-opcode operations that a serial NAND device needs. A request names the kind of transaction (page read, page program or block erase), a row (page or block) address, a column offset inside the page, a byte count and a poll budget. The sequencer hands one operation descriptor at a time to a lower-level serial operation engine. Each descriptor carries an opcode, an address, the number of address bytes, the number of dummy bytes, the data direction and the data length. The sequencer waits for the engine to report completion before it hands over the next descriptor.

After the command that starts the array operation, the sequencer reads the status register again and again until the device reports ready. It then judges pass or fail from the status bits that belong to the transaction kind. On a failed or timed-out program or erase it turns the write latch off again. It signals completion with a single-cycle pulse and a two-bit result code. Bad-block handling and error correction are left to the layers above.

Top module: `nand_txn_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `req_ready` is 1, `done` is 0 and `op_start` is 0.
- R2: A program request (kind 1) issues opcodes 0x06, then 0x02, then 0x10, then status polls. The 0x02 operation carries the column address in 2 address bytes, direction out (code 2) and length equal to the byte count. The 0x10 operation carries the row address in 3 address bytes and direction none (code 0).
- R3: An erase request (kind 2) issues 0x06, then 0xD8 with the row address in 3 address bytes, then status polls.
- R4: A read request (kind 0) issues 0x13 with the row address in 3 address bytes, then status polls, then a cache read with the column address in 2 address bytes, direction in (code 1) and length equal to the byte count. With `req_fast` low the cache read is opcode 0x03 with 0 dummy bytes. With `req_fast` high it is opcode 0x0B with 1 dummy byte.
- R5: Every status poll is opcode 0x0F with address 0xC0 in 1 address byte, direction in and length 1. Polling repeats for as long as bit 0 (busy) of the returned byte is 1.
- R6: A program whose final status has bit 3 set, or an erase whose final status has bit 2 set, issues 0x04 after the last poll and completes with result 1 (fail).
- R7: A program ignores status bit 2 and an erase ignores status bit 3. With the relevant bit clear, each completes with result 0 (pass) and issues no 0x04.
- R8: If `poll_limit` consecutive polls all return busy, the transaction ends with result 2 (timeout) and issues no further polls. A program or erase then issues 0x04 first. A read issues no cache read.
- R9: `done` and `op_start` are single-cycle pulses. No `op_start` is issued while an earlier operation has not yet returned `op_done`. `result` is never 3.
- R10: A request with kind 3 is ignored: no operation is issued, no `done` appears and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Sequencer idle |
| req_kind | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| req_fast | input | 1 | Read uses the fast cache-read form |
| req_row | input | 24 | Row (page/block) address |
| req_col | input | 16 | Column offset in the page |
| req_len | input | 16 | Data byte count |
| poll_limit | input | 16 | Maximum number of busy status replies |
| op_start | output | 1 | Descriptor valid pulse to the engine |
| op_code | output | 8 | Opcode |
| op_addr | output | 24 | Address value |
| op_addr_bytes | output | 2 | Number of address bytes |
| op_dummy_bytes | output | 2 | Number of dummy bytes |
| op_dir | output | 2 | 0 none, 1 in, 2 out |
| op_len | output | 16 | Data length in bytes |
| op_done | input | 1 | Engine finished the current operation |
| op_rdata | input | 8 | Byte read by the last operation (status) |
| done | output | 1 | Transaction complete pulse |
| result | output | 2 | 0 pass, 1 fail, 2 timeout |

## Verification
The checks assume that the engine raises `op_done` only while an operation is outstanding, and only for one cycle. They also assume that `req_valid` is sampled only while `req_ready` is high. The bench models the engine as a responder that answers each `op_start` exactly once, a fixed two cycles later. It scripts status replies as a number of busy replies followed by one final byte. It strobes requests only while the sequencer is idle, so the assumptions hold for every scenario.

// File: rtl/nand_txn_pkg.sv
package nand_txn_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_LOAD  = 8'h02;
  localparam logic [7:0] OP_EXEC  = 8'h10;
  localparam logic [7:0] OP_ERASE = 8'hD8;
  localparam logic [7:0] OP_PREAD = 8'h13;
  localparam logic [7:0] OP_CRD   = 8'h03;
  localparam logic [7:0] OP_CRDF  = 8'h0B;
  localparam logic [7:0] OP_GETF  = 8'h0F;
  localparam logic [7:0] STAT_REG = 8'hC0;

  localparam int BUSY_BIT  = 0;
  localparam int EFAIL_BIT = 2;
  localparam int PFAIL_BIT = 3;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_PROG  = 2'd1;
  localparam logic [1:0] KIND_ERASE = 2'd2;

  localparam logic [1:0] DIR_NONE = 2'd0;
  localparam logic [1:0] DIR_IN   = 2'd1;
  localparam logic [1:0] DIR_OUT  = 2'd2;

  localparam logic [1:0] RES_PASS    = 2'd0;
  localparam logic [1:0] RES_FAIL    = 2'd1;
  localparam logic [1:0] RES_TIMEOUT = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WREN, ST_LOAD, ST_EXEC, ST_ERASE,
    ST_PREAD, ST_POLL, ST_CREAD, ST_WRDI, ST_DONE
  } step_e;
endpackage

// File: rtl/nand_txn_status.sv
module nand_txn_status
  import nand_txn_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [7:0] status,
  output logic       busy,
  output logic       failed
);
  always_comb begin
    busy   = status[BUSY_BIT];
    failed = 1'b0;
    case (kind)
      KIND_PROG:  failed = status[PFAIL_BIT];
      KIND_ERASE: failed = status[EFAIL_BIT];
      default:    failed = 1'b0;
    endcase
  end
endmodule

// File: rtl/nand_txn_poll_ctr.sv
module nand_txn_poll_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  // the next busy reply would be reply number cnt+1
  assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (bump)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nand_txn_desc.sv
module nand_txn_desc
  import nand_txn_pkg::*;
#(
  parameter int ROW_BYTES = 3,
  parameter int COL_BYTES = 2,
  parameter int LEN_W     = 16,
  localparam int ROW_W    = 8 * ROW_BYTES,
  localparam int COL_W    = 8 * COL_BYTES
) (
  input  step_e             step,
  input  logic              fast,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [LEN_W-1:0]  len,
  output logic [7:0]        code,
  output logic [ROW_W-1:0]  addr,
  output logic [1:0]        abytes,
  output logic [1:0]        dummy,
  output logic [1:0]        dir,
  output logic [LEN_W-1:0]  dlen
);
  always_comb begin
    code   = 8'h00;
    addr   = '0;
    abytes = 2'd0;
    dummy  = 2'd0;
    dir    = DIR_NONE;
    dlen   = '0;
    case (step)
      ST_WREN: code = OP_WREN;
      ST_WRDI: code = OP_WRDI;
      ST_LOAD: begin
        code = OP_LOAD; addr = ROW_W'(col); abytes = 2'(COL_BYTES);
        dir = DIR_OUT; dlen = len;
      end
      ST_EXEC:  begin code = OP_EXEC;  addr = row; abytes = 2'(ROW_BYTES); end
      ST_ERASE: begin code = OP_ERASE; addr = row; abytes = 2'(ROW_BYTES); end
      ST_PREAD: begin code = OP_PREAD; addr = row; abytes = 2'(ROW_BYTES); end
      ST_POLL: begin
        code = OP_GETF; addr = ROW_W'(STAT_REG); abytes = 2'd1;
        dir = DIR_IN; dlen = LEN_W'(1);
      end
      ST_CREAD: begin
        code = fast ? OP_CRDF : OP_CRD; addr = ROW_W'(col);
        abytes = 2'(COL_BYTES); dummy = fast ? 2'd1 : 2'd0;
        dir = DIR_IN; dlen = len;
      end
      default: code = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_txn_seq.sv
module nand_txn_seq
  import nand_txn_pkg::*;
#(
  parameter int ROW_BYTES = 3,
  parameter int COL_BYTES = 2,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 16,
  localparam int ROW_W    = 8 * ROW_BYTES,
  localparam int COL_W    = 8 * COL_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_fast,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [CNT_W-1:0]  poll_limit,
  output logic              op_start,
  output logic [7:0]        op_code,
  output logic [ROW_W-1:0]  op_addr,
  output logic [1:0]        op_addr_bytes,
  output logic [1:0]        op_dummy_bytes,
  output logic [1:0]        op_dir,
  output logic [LEN_W-1:0]  op_len,
  input  logic              op_done,
  input  logic [7:0]        op_rdata,
  output logic              done,
  output logic [1:0]        result
);
  step_e            st, nxt;
  logic             wait_q;
  logic [1:0]       kind_q, res_q, nxt_res;
  logic             fast_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] limit_q;
  logic             st_busy, st_failed, poll_last;
  logic [7:0]       d_code;
  logic [ROW_W-1:0] d_addr;
  logic [1:0]       d_abytes, d_dummy, d_dir;
  logic [LEN_W-1:0] d_len;
  logic             accept, poll_reply;

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_ready && req_valid && (req_kind != 2'd3);
  assign poll_reply = (st == ST_POLL) && wait_q && op_done;

  nand_txn_status u_status (
    .kind(kind_q), .status(op_rdata), .busy(st_busy), .failed(st_failed)
  );

  nand_txn_poll_ctr #(.CNT_W(CNT_W)) u_poll (
    .clk(clk), .rst(rst), .clear(accept), .bump(poll_reply && st_busy),
    .limit(limit_q), .last(poll_last)
  );

  nand_txn_desc #(.ROW_BYTES(ROW_BYTES), .COL_BYTES(COL_BYTES), .LEN_W(LEN_W)) u_desc (
    .step(st), .fast(fast_q), .row(row_q), .col(col_q), .len(len_q),
    .code(d_code), .addr(d_addr), .abytes(d_abytes), .dummy(d_dummy),
    .dir(d_dir), .dlen(d_len)
  );

  // step that follows the completion of the current operation
  always_comb begin
    nxt     = st;
    nxt_res = res_q;
    case (st)
      ST_WREN:  nxt = (kind_q == KIND_PROG) ? ST_LOAD : ST_ERASE;
      ST_LOAD:  nxt = ST_EXEC;
      ST_EXEC, ST_ERASE, ST_PREAD: nxt = ST_POLL;
      ST_POLL: begin
        if (st_busy) begin
          if (poll_last) begin
            nxt_res = RES_TIMEOUT;
            nxt     = (kind_q == KIND_READ) ? ST_DONE : ST_WRDI;
          end else begin
            nxt = ST_POLL;
          end
        end else if (kind_q == KIND_READ) begin
          nxt = ST_CREAD;
        end else if (st_failed) begin
          nxt_res = RES_FAIL;
          nxt     = ST_WRDI;
        end else begin
          nxt_res = RES_PASS;
          nxt     = ST_DONE;
        end
      end
      ST_CREAD: begin nxt_res = RES_PASS; nxt = ST_DONE; end
      ST_WRDI:  nxt = ST_DONE;
      default:  nxt = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; wait_q <= 1'b0; kind_q <= KIND_READ; fast_q <= 1'b0;
      row_q <= '0; col_q <= '0; len_q <= '0; limit_q <= '0; res_q <= RES_PASS;
      op_start <= 1'b0; op_code <= 8'h00; op_addr <= '0; op_addr_bytes <= 2'd0;
      op_dummy_bytes <= 2'd0; op_dir <= DIR_NONE; op_len <= '0;
      done <= 1'b0; result <= RES_PASS;
    end else begin
      op_start <= 1'b0;
      done     <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          kind_q <= req_kind; fast_q <= req_fast; row_q <= req_row;
          col_q <= req_col; len_q <= req_len; limit_q <= poll_limit;
          res_q <= RES_PASS;
          st    <= (req_kind == KIND_READ) ? ST_PREAD : ST_WREN;
        end
        ST_DONE: begin
          done   <= 1'b1;
          result <= res_q;
          st     <= ST_IDLE;
        end
        default: begin
          if (!wait_q) begin
            op_start <= 1'b1; op_code <= d_code; op_addr <= d_addr;
            op_addr_bytes <= d_abytes; op_dummy_bytes <= d_dummy;
            op_dir <= d_dir; op_len <= d_len;
            wait_q <= 1'b1;
          end else if (op_done) begin
            wait_q <= 1'b0;
            st     <= nxt;
            res_q  <= nxt_res;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_txn_seq_chk.sv
module nand_txn_seq_chk #(
  parameter int ROW_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             op_start,
  input logic [7:0]       op_code,
  input logic [ROW_W-1:0] op_addr,
  input logic [1:0]       op_addr_bytes,
  input logic [1:0]       op_dir,
  input logic             op_done,
  input logic             done,
  input logic [1:0]       result,
  input logic             req_ready
);
  logic outst;
  always_ff @(posedge clk) begin
    if (rst)           outst <= 1'b0;
    else if (op_start) outst <= 1'b1;
    else if (op_done)  outst <= 1'b0;
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    op_start |-> !outst); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (rst)
    done |-> result != 2'd3); // R9
  AST_POLL_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_code == 8'h0F) |-> (op_addr == ROW_W'(8'hC0) && op_addr_bytes == 2'd1 && op_dir == 2'd1)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !op_start && !outst); // R10
endmodule

bind nand_txn_seq nand_txn_seq_chk #(.ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst(rst), .op_start(op_start), .op_code(op_code),
  .op_addr(op_addr), .op_addr_bytes(op_addr_bytes), .op_dir(op_dir),
  .op_done(op_done), .done(done), .result(result), .req_ready(req_ready)
);

// File: tb/nand_txn_seq_tb_top.sv
module nand_txn_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOGD = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_fast;
  logic [1:0]  req_kind;
  logic [23:0] req_row;
  logic [15:0] req_col, req_len, poll_limit;
  logic        op_start, op_done, done;
  logic [7:0]  op_code, op_rdata;
  logic [23:0] op_addr;
  logic [1:0]  op_addr_bytes, op_dummy_bytes, op_dir, result;
  logic [15:0] op_len;

  int n_chk = 0, n_bad = 0;
  int busy_polls, poll_seen, lg_n;
  logic [7:0] final_status;
  logic [7:0]  lg_code [LOGD];
  logic [23:0] lg_addr [LOGD];
  logic [1:0]  lg_ab [LOGD], lg_dm [LOGD], lg_dir [LOGD];
  logic [15:0] lg_len [LOGD];
  logic [1:0]  got_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_txn_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_fast(req_fast), .req_row(req_row),
    .req_col(req_col), .req_len(req_len), .poll_limit(poll_limit),
    .op_start(op_start), .op_code(op_code), .op_addr(op_addr),
    .op_addr_bytes(op_addr_bytes), .op_dummy_bytes(op_dummy_bytes),
    .op_dir(op_dir), .op_len(op_len), .op_done(op_done), .op_rdata(op_rdata),
    .done(done), .result(result)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // engine model: answers each operation two cycles after it starts
  initial begin
    op_done = 1'b0; op_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (op_start) begin
        if (lg_n < LOGD) begin
          lg_code[lg_n] = op_code; lg_addr[lg_n] = op_addr; lg_ab[lg_n] = op_addr_bytes;
          lg_dm[lg_n] = op_dummy_bytes; lg_dir[lg_n] = op_dir; lg_len[lg_n] = op_len;
        end
        lg_n++;
        repeat (2) @(negedge clk);
        if (op_code == 8'h0F) begin
          op_rdata = (poll_seen < busy_polls) ? 8'h01 : final_status;
          poll_seen++;
        end else op_rdata = 8'h00;
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
      end
    end
  end

  task automatic run_txn(input string req, input logic [1:0] kind, input logic fast,
                         input logic [23:0] row, input logic [15:0] col, input logic [15:0] len,
                         input logic [15:0] limit, input int nbusy, input logic [7:0] fin);
    bit seen = 0;
    lg_n = 0; poll_seen = 0; busy_polls = nbusy; final_status = fin;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_fast = fast; req_row = row;
    req_col = col; req_len = len; poll_limit = limit;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    check(req, "done seen", seen, 1);
    got_res = result;
    @(negedge clk);
    check("R9", "done single cycle", done, 0);
  endtask

  task automatic check_seq(input string req, input int n, input logic [63:0] exp);
    check(req, "op count", lg_n, n);
    for (int i = 0; i < n && i < 8; i++)
      check(req, $sformatf("opcode %0d", i), lg_code[i], exp[8*(n-1-i) +: 8]);
  endtask

  task automatic t_reset;
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_fast = 1'b0;
    req_row = '0; req_col = '0; req_len = '0; poll_limit = 16'd8; lg_n = 0;
    busy_polls = 0; poll_seen = 0; final_status = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "ready", req_ready, 1);
    check("R1", "done", done, 0);
    check("R1", "op_start", op_start, 0);
  endtask

  task automatic t_prog_pass;
    run_txn("R2", 2'd1, 1'b0, 24'h01A2B3, 16'h0123, 16'd512, 16'd8, 2, 8'h00);
    check_seq("R2", 6, 64'h06_02_10_0F_0F_0F);
    check("R2", "result", got_res, 0);
    check("R2", "load addr", lg_addr[1], 24'h000123);
    check("R2", "load abytes", lg_ab[1], 2);
    check("R2", "load dir", lg_dir[1], 2);
    check("R2", "load len", lg_len[1], 512);
    check("R2", "exec addr", lg_addr[2], 24'h01A2B3);
    check("R2", "exec abytes", lg_ab[2], 3);
    check("R2", "exec dir", lg_dir[2], 0);
    check("R5", "poll addr", lg_addr[3], 24'h0000C0);
    check("R5", "poll abytes", lg_ab[4], 1);
    check("R5", "poll dir", lg_dir[5], 1);
    check("R5", "poll len", lg_len[5], 1);
  endtask

  task automatic t_prog_fail;
    run_txn("R6", 2'd1, 1'b0, 24'h000040, 16'h0000, 16'd16, 16'd8, 0, 8'h08);
    check_seq("R6", 5, 64'h06_02_10_0F_04);
    check("R6", "program fail result", got_res, 1);
    run_txn("R7", 2'd1, 1'b0, 24'h000041, 16'h0000, 16'd16, 16'd8, 1, 8'h04);
    check_seq("R7", 5, 64'h06_02_10_0F_0F);
    check("R7", "program ignores bit2", got_res, 0);
  endtask

  task automatic t_erase;
    run_txn("R3", 2'd2, 1'b0, 24'h0ABC00, 16'h0000, 16'd0, 16'd8, 1, 8'h00);
    check_seq("R3", 4, 64'h06_D8_0F_0F);
    check("R3", "erase addr", lg_addr[1], 24'h0ABC00);
    check("R3", "erase abytes", lg_ab[1], 3);
    check("R3", "result", got_res, 0);
    run_txn("R6", 2'd2, 1'b0, 24'h000100, 16'h0000, 16'd0, 16'd8, 0, 8'h04);
    check_seq("R6", 4, 64'h06_D8_0F_04);
    check("R6", "erase fail result", got_res, 1);
    run_txn("R7", 2'd2, 1'b0, 24'h000200, 16'h0000, 16'd0, 16'd8, 0, 8'h08);
    check_seq("R7", 3, 64'h06_D8_0F);
    check("R7", "erase ignores bit3", got_res, 0);
  endtask

  task automatic t_read;
    run_txn("R4", 2'd0, 1'b0, 24'h00F00D, 16'h0800, 16'd64, 16'd8, 0, 8'h00);
    check_seq("R4", 3, 64'h13_0F_03);
    check("R4", "pread addr", lg_addr[0], 24'h00F00D);
    check("R4", "pread abytes", lg_ab[0], 3);
    check("R4", "cread addr", lg_addr[2], 24'h000800);
    check("R4", "cread abytes", lg_ab[2], 2);
    check("R4", "cread dummy", lg_dm[2], 0);
    check("R4", "cread dir", lg_dir[2], 1);
    check("R4", "cread len", lg_len[2], 64);
    check("R4", "result", got_res, 0);
    run_txn("R4", 2'd0, 1'b1, 24'h000123, 16'h0010, 16'd2048, 16'd8, 1, 8'h00);
    check_seq("R4", 4, 64'h13_0F_0F_0B);
    check("R4", "fast dummy", lg_dm[3], 1);
    check("R4", "fast len", lg_len[3], 2048);
  endtask

  task automatic t_timeout;
    run_txn("R8", 2'd2, 1'b0, 24'h000300, 16'h0000, 16'd0, 16'd3, 100, 8'h00);
    check_seq("R8", 6, 64'h06_D8_0F_0F_0F_04);
    check("R8", "erase timeout result", got_res, 2);
    run_txn("R8", 2'd0, 1'b0, 24'h000301, 16'h0000, 16'd8, 16'd2, 100, 8'h00);
    check_seq("R8", 3, 64'h13_0F_0F);
    check("R8", "read timeout result", got_res, 2);
  endtask

  task automatic t_bad_kind;
    bit any_done = 0;
    lg_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (done) any_done = 1;
      @(negedge clk);
    end
    check("R10", "ops issued", lg_n, 0);
    check("R10", "done seen", any_done, 0);
    check("R10", "ready", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_prog_pass();
    t_prog_fail();
    t_erase();
    t_read();
    t_timeout();
    t_bad_kind();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule